// File: doc/BRIEF.md
# Block-Transfer Host Register Port

This block is the host-facing register window of a block-transfer management channel. A host reaches it through a byte-wide address/data bus with separate read and write strobes. There are three registers: a control/status register, a data port and an interrupt mask register. Data-port writes fill an inbound request buffer. Data-port reads drain an outbound response buffer. The control register carries the busy and attention flags that the two sides use to hand messages back and forth.

A message engine sits on the other side of the buffers.

- When the host triggers attention, the engine sees a one-cycle request pulse and the inbound byte count.
- The engine reads the request bytes through a read port with a one-cycle latency.
- It writes the response bytes into the outbound buffer and then posts the response length.
- It can raise or drop a separate system-management attention flag.

The block keeps one interrupt-pending bit. It drives a registered, level-sensitive interrupt line from that bit, gated by a global interrupt-allowed input.

Both buffers are simple dual-port memories, each with one write port and one registered read port, so that block RAM can be inferred. The buffer depth is a parameter. The inbound byte counter is 8 bits wide and saturates.

Top module: `bt_host_port`

## Requirements
- R1: A synchronous reset clears every flag, both buffer counters, interrupt enable, interrupt pending and the irq output, so the control and mask registers both read 0x00.
- R2: Reads are decoded on host_addr: 0 returns the control register, 1 returns data, 2 returns the mask register and 3 returns 0xFF. Read data appears on host_rdata one cycle after the host_rd strobe. The control register reads as {BMC busy (bit 7), host busy (bit 6), 0, SMS attention (bit 4), BMC-to-host attention (bit 3), 3'b000}. The mask register reads as {6'b0, pending (bit 1), enable (bit 0)}.
- R3: A data-port write stores its byte at index in_len only while in_len is below the buffer depth. in_len is incremented on every data-port write and saturates at 255, and bytes beyond the depth leave the stored bytes unchanged.
- R4: In a control write, a 1 in bit 0 sets in_len to zero, and a 1 in bit 1 returns the outbound read position to the first byte of the current response.
- R5: In a control write, a 1 in bit 3 clears BMC-to-host attention, a 1 in bit 4 clears SMS attention, and a 1 in bit 6 inverts host busy. A 0 in any of these bits leaves the flag unchanged.
- R6: A control write with bit 2 set sets BMC busy and produces a one-cycle req_ready pulse in the following cycle.
- R7: rsp_post sets the outbound length to rsp_len, clamped to the buffer depth. It also clears BMC busy and sets BMC-to-host attention. Data-port reads then return the response bytes in index order. After the last byte, position and length return to zero, and a data read with nothing pending returns 0xFF.
- R8: Turning the enable bit (mask bit 0) from 0 to 1 sets pending if either attention flag is set. Turning it from 1 to 0 clears pending. Writing the value enable already has does not change pending.
- R9: A mask write with bit 1 set clears pending, and this is evaluated after the enable change of the same write.
- R10: rsp_post sets pending only while enable is 1.
- R11: A rising SMS update (sms_upd with sms_val = 1 while the flag is clear) sets pending only if enable is 1 and BMC-to-host attention is clear. A falling SMS update clears pending only if BMC-to-host attention is clear.
- R12: irq is a register that follows pending ANDed with irq_allow, with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register select |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Read data, valid the cycle after host_rd |
| req_ready | output | 1 | One-cycle pulse: request submitted |
| in_len | output | 8 | Inbound byte count (saturating) |
| in_rd_idx | input | IDX_W | Engine read index into the inbound buffer |
| in_rd_data | output | 8 | Inbound byte, one cycle after the index |
| out_wr_en | input | 1 | Engine write enable for the outbound buffer |
| out_wr_idx | input | IDX_W | Outbound write index |
| out_wr_data | input | 8 | Outbound write byte |
| rsp_post | input | 1 | Response complete strobe |
| rsp_len | input | 8 | Response length in bytes |
| sms_upd | input | 1 | SMS attention update strobe |
| sms_val | input | 1 | New SMS attention value |
| irq_allow | input | 1 | Global interrupt permission |
| irq | output | 1 | Level interrupt output |

## Verification
The bench runs the design with a depth of 8 and targets the following corner cases.

- **Inbound overrun.** It writes 260 bytes. A counter that wraps would read back a small length, and a store with a wrapped index would overwrite the first eight request bytes.
- **Response lengths.** It sweeps every length from 1 to the depth, plus one length that must be clamped. An off-by-one in the end-of-message reset would either drop a byte or return a stale byte where 0xFF is expected.
- **Interrupt ordering.** It enables interrupts while attention is already set, and it combines enable with the acknowledge bit in one write. It also raises and drops SMS attention with BMC-to-host attention both set and clear. An implementation that used the wrong evaluation order or the wrong gating would leave pending set or clear when it should not.
- **Interrupt gating.** It toggles irq_allow and checks the irq line against the pending bit seen through the mask register.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int LEN_W = 8;
  localparam int BYTE_W = 8;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_MASK = 2'd2;

  // control register bit positions (host software decodes these)
  localparam int CB_CLR_IN  = 0;
  localparam int CB_CLR_OUT = 1;
  localparam int CB_KICK    = 2;
  localparam int CB_B2H     = 3;
  localparam int CB_SMS     = 4;
  localparam int CB_HBUSY   = 6;
  localparam int CB_BBUSY   = 7;

  localparam int MB_EN   = 0;
  localparam int MB_PEND = 1;

  localparam logic [BYTE_W-1:0] EMPTY_BYTE = 8'hFF;
endpackage

// File: rtl/bt_inbound_buf.sv
module bt_inbound_buf
  import bt_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              clr,
  output logic [LEN_W-1:0]  len,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic              room;

  assign room = 32'(len) < DEPTH;

  // memory: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_en && room) mem[len[IDX_W-1:0]] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)                        len <= '0;
    else if (clr)                   len <= '0;
    else if (wr_en && (len != '1))  len <= len + 1'b1;
  end
endmodule

// File: rtl/bt_outbound_buf.sv
module bt_outbound_buf
  import bt_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [BYTE_W-1:0] eng_data,
  input  logic              load,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              clr_pos,
  input  logic              rd_en,
  output logic              avail,
  output logic [BYTE_W-1:0] rd_q
);
  localparam logic [LEN_W-1:0] DEPTH_LEN = LEN_W'(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [LEN_W-1:0]  pos, len;

  assign avail = pos < len;

  always_ff @(posedge clk) begin
    if (eng_we) mem[eng_idx] <= eng_data;
    if (rd_en && avail) rd_q <= mem[pos[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      len <= '0;
    end else begin
      if (rd_en && avail) begin
        if (pos + 1'b1 == len) begin
          pos <= '0;
          len <= '0;
        end else begin
          pos <= pos + 1'b1;
        end
      end
      if (clr_pos) pos <= '0;
      if (load) len <= (load_len > DEPTH_LEN) ? DEPTH_LEN : load_len;
    end
  end
endmodule

// File: rtl/bt_irq_ctrl.sv
module bt_irq_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       mask_wr,
  input  logic [1:0] mask_wdata,
  input  logic       rsp_post,
  input  logic       sms_rise,
  input  logic       sms_fall,
  input  logic       b2h_q,
  input  logic       sms_q,
  input  logic       irq_allow,
  output logic       en_q,
  output logic       pend_q,
  output logic       irq
);
  logic en_n, pend_n;

  always_comb begin
    en_n   = en_q;
    pend_n = pend_q;
    // host mask write first: enable edge, then acknowledge
    if (mask_wr) begin
      if (mask_wdata[0] != en_q) begin
        if (mask_wdata[0]) begin
          if (b2h_q || sms_q) pend_n = 1'b1;
          en_n = 1'b1;
        end else begin
          pend_n = 1'b0;
          en_n   = 1'b0;
        end
      end
      if (mask_wdata[1] && pend_n) pend_n = 1'b0;
    end
    // engine-side events after the host write
    if (rsp_post && en_n) pend_n = 1'b1;
    if (sms_rise && en_n && !b2h_q) pend_n = 1'b1;
    if (sms_fall && !b2h_q) pend_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      en_q   <= en_n;
      pend_q <= pend_n;
      irq    <= pend_n & irq_allow;
    end
  end
endmodule

// File: rtl/bt_host_port.sv
module bt_host_port
  import bt_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  parameter int IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              req_ready,
  output logic [LEN_W-1:0]  in_len,
  input  logic [IDX_W-1:0]  in_rd_idx,
  output logic [BYTE_W-1:0] in_rd_data,
  input  logic              out_wr_en,
  input  logic [IDX_W-1:0]  out_wr_idx,
  input  logic [BYTE_W-1:0] out_wr_data,
  input  logic              rsp_post,
  input  logic [LEN_W-1:0]  rsp_len,
  input  logic              sms_upd,
  input  logic              sms_val,
  input  logic              irq_allow,
  output logic              irq
);
  logic ctl_wr, data_wr, mask_wr, data_rd;
  logic b2h_q, sms_q, hbusy_q, bbusy_q;
  logic sms_rise, sms_fall;
  logic en_q, pend_q;
  logic out_avail;
  logic [BYTE_W-1:0] out_rd_q, rd_hold;
  logic rd_from_mem;
  logic [BYTE_W-1:0] ctl_view, mask_view;

  assign ctl_wr  = host_wr && (host_addr == ADDR_CTL);
  assign data_wr = host_wr && (host_addr == ADDR_DATA);
  assign mask_wr = host_wr && (host_addr == ADDR_MASK);
  assign data_rd = host_rd && (host_addr == ADDR_DATA);

  assign sms_rise = sms_upd &&  sms_val && !sms_q;
  assign sms_fall = sms_upd && !sms_val &&  sms_q;

  // control flags
  always_ff @(posedge clk) begin
    if (rst) begin
      b2h_q     <= 1'b0;
      sms_q     <= 1'b0;
      hbusy_q   <= 1'b0;
      bbusy_q   <= 1'b0;
      req_ready <= 1'b0;
    end else begin
      req_ready <= ctl_wr && host_wdata[CB_KICK];
      if (ctl_wr) begin
        if (host_wdata[CB_B2H])   b2h_q   <= 1'b0;
        if (host_wdata[CB_SMS])   sms_q   <= 1'b0;
        if (host_wdata[CB_HBUSY]) hbusy_q <= ~hbusy_q;
        if (host_wdata[CB_KICK])  bbusy_q <= 1'b1;
      end
      if (sms_rise) sms_q <= 1'b1;
      if (sms_fall) sms_q <= 1'b0;
      if (rsp_post) begin
        bbusy_q <= 1'b0;
        b2h_q   <= 1'b1;
      end
    end
  end

  bt_inbound_buf #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_in (
    .clk(clk), .rst(rst),
    .wr_en(data_wr), .wr_data(host_wdata),
    .clr(ctl_wr && host_wdata[CB_CLR_IN]),
    .len(in_len), .rd_idx(in_rd_idx), .rd_data(in_rd_data)
  );

  bt_outbound_buf #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst(rst),
    .eng_we(out_wr_en), .eng_idx(out_wr_idx), .eng_data(out_wr_data),
    .load(rsp_post), .load_len(rsp_len),
    .clr_pos(ctl_wr && host_wdata[CB_CLR_OUT]),
    .rd_en(data_rd), .avail(out_avail), .rd_q(out_rd_q)
  );

  bt_irq_ctrl u_irq (
    .clk(clk), .rst(rst),
    .mask_wr(mask_wr), .mask_wdata(host_wdata[1:0]),
    .rsp_post(rsp_post), .sms_rise(sms_rise), .sms_fall(sms_fall),
    .b2h_q(b2h_q), .sms_q(sms_q), .irq_allow(irq_allow),
    .en_q(en_q), .pend_q(pend_q), .irq(irq)
  );

  always_comb begin
    ctl_view = '0;
    ctl_view[CB_BBUSY] = bbusy_q;
    ctl_view[CB_HBUSY] = hbusy_q;
    ctl_view[CB_SMS]   = sms_q;
    ctl_view[CB_B2H]   = b2h_q;
    mask_view = '0;
    mask_view[MB_EN]   = en_q;
    mask_view[MB_PEND] = pend_q;
  end

  // read path: register holds the selected value, memory has its own read register
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hold     <= '0;
      rd_from_mem <= 1'b0;
    end else if (host_rd) begin
      rd_from_mem <= data_rd && out_avail;
      case (host_addr)
        ADDR_CTL:  rd_hold <= ctl_view;
        ADDR_MASK: rd_hold <= mask_view;
        default:   rd_hold <= EMPTY_BYTE;
      endcase
    end
  end

  assign host_rdata = rd_from_mem ? out_rd_q : rd_hold;
endmodule

// File: rtl/bt_host_port_chk.sv
module bt_host_port_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] host_addr,
  input logic [7:0] host_wdata,
  input logic       host_wr,
  input logic       req_ready,
  input logic [7:0] in_len,
  input logic       rsp_post,
  input logic       irq_allow,
  input logic       irq,
  input logic       en_q,
  input logic       pend_q,
  input logic       b2h_q,
  input logic       bbusy_q
);
  assert_req_source_R6: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> $past(host_wr && host_addr == 2'd0 && host_wdata[2]));

  assert_req_follows_R6: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd0 && host_wdata[2]) |=> (req_ready && bbusy_q));

  assert_len_saturates_R3: assert property (@(posedge clk) disable iff (rst)
    (in_len == 8'hFF && !(host_wr && host_addr == 2'd0 && host_wdata[0])) |=> in_len == 8'hFF);

  assert_post_flags_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_post |=> (b2h_q && !bbusy_q));

  assert_pend_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> en_q);

  assert_irq_gated_R12: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pend_q && $past(irq_allow)));
endmodule

bind bt_host_port bt_host_port_chk u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_wr(host_wr), .req_ready(req_ready), .in_len(in_len),
  .rsp_post(rsp_post), .irq_allow(irq_allow), .irq(irq),
  .en_q(en_q), .pend_q(pend_q), .b2h_q(b2h_q), .bbusy_q(bbusy_q)
);

// File: tb/bt_host_port_tb.sv
`timescale 1ns/1ps
module bt_host_port_tb;
  localparam int DEPTH = 8;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic req_ready;
  logic [7:0] in_len;
  logic [IW-1:0] in_rd_idx = '0;
  logic [7:0] in_rd_data;
  logic out_wr_en = 1'b0;
  logic [IW-1:0] out_wr_idx = '0;
  logic [7:0] out_wr_data = '0;
  logic rsp_post = 1'b0;
  logic [7:0] rsp_len = '0;
  logic sms_upd = 1'b0, sms_val = 1'b0;
  logic irq_allow = 1'b1;
  logic irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bt_host_port #(.BUF_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .req_ready(req_ready), .in_len(in_len), .in_rd_idx(in_rd_idx),
    .in_rd_data(in_rd_data), .out_wr_en(out_wr_en), .out_wr_idx(out_wr_idx),
    .out_wr_data(out_wr_data), .rsp_post(rsp_post), .rsp_len(rsp_len),
    .sms_upd(sms_upd), .sms_val(sms_val), .irq_allow(irq_allow), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic in_peek(input int idx, output logic [7:0] d);
    @(negedge clk);
    in_rd_idx = IW'(idx);
    @(negedge clk);
    d = in_rd_data;
  endtask

  function automatic logic [7:0] req_byte(input int k);
    return 8'((k * 37 + 5) & 8'hFF);
  endfunction

  function automatic logic [7:0] rsp_byte(input int r, input int k);
    return 8'((r * 17 + k * 29 + 3) & 8'hFF);
  endfunction

  task automatic post(input int r, input int n);
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      out_wr_en = 1'b1; out_wr_idx = IW'(k); out_wr_data = rsp_byte(r, k);
    end
    @(negedge clk);
    out_wr_en = 1'b0; rsp_post = 1'b1; rsp_len = 8'(n);
    @(negedge clk);
    rsp_post = 1'b0;
  endtask

  task automatic sms(input logic v);
    @(negedge clk);
    sms_upd = 1'b1; sms_val = v;
    @(negedge clk);
    sms_upd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    hrd(2'd0, d); check("R1 ctl after reset", d, 8'h00);
    hrd(2'd2, d); check("R1 mask after reset", d, 8'h00);
    check("R1 in_len after reset", in_len, 0);
    check("R1 irq after reset", irq, 0);

    // R2 decode
    hrd(2'd3, d); check("R2 offset 3 reads FF", d, 8'hFF);
    hrd(2'd1, d); check("R7 empty data read", d, 8'hFF);

    // R3 inbound fill with overrun
    for (int i = 0; i < 10; i++) begin
      hwr(2'd1, req_byte(i));
      check("R3 in_len step", in_len, i + 1);
    end
    for (int k = 0; k < DEPTH; k++) begin
      in_peek(k, d); check("R3 stored byte", d, req_byte(k));
    end
    for (int i = 10; i < 260; i++) hwr(2'd1, 8'hA5);
    check("R3 in_len saturates at 255", in_len, 255);
    for (int k = 0; k < DEPTH; k++) begin
      in_peek(k, d); check("R3 overrun leaves bytes", d, req_byte(k));
    end

    // R4 clear inbound
    hwr(2'd0, 8'h01); check("R4 clear write pointer", in_len, 0);
    hwr(2'd1, 8'h5C); in_peek(0, d); check("R4 write restarts at 0", d, 8'h5C);

    // R5 host busy toggle
    hwr(2'd0, 8'h40); hrd(2'd0, d); check("R5 host busy set", d, 8'h40);
    hwr(2'd0, 8'h40); hrd(2'd0, d); check("R5 host busy cleared", d, 8'h00);

    // R6 kick
    hwr(2'd0, 8'h04);
    check("R6 req_ready pulse", req_ready, 1);
    @(negedge clk); check("R6 req_ready one cycle", req_ready, 0);
    hrd(2'd0, d); check("R6 BMC busy set", d, 8'h80);

    // R7 response length sweep
    for (int n = 1; n <= DEPTH; n++) begin
      post(n, n);
      hrd(2'd0, d); check("R7 flags after post", d, 8'h08);
      for (int k = 0; k < n; k++) begin
        hrd(2'd1, d); check("R7 response byte", d, rsp_byte(n, k));
      end
      hrd(2'd1, d); check("R7 drained reads FF", d, 8'hFF);
    end
    post(20, 10);
    for (int k = 0; k < DEPTH; k++) begin
      hrd(2'd1, d); check("R7 clamped byte", d, rsp_byte(20, k));
    end
    hrd(2'd1, d); check("R7 clamped length end", d, 8'hFF);

    // R4 clear read pointer
    post(21, 4);
    hrd(2'd1, d); hrd(2'd1, d);
    hwr(2'd0, 8'h02);
    hrd(2'd1, d); check("R4 read pointer rewound", d, rsp_byte(21, 0));
    hwr(2'd0, 8'h02);

    // R5 W1C b2h; zero bits leave flags
    hwr(2'd0, 8'h00); hrd(2'd0, d); check("R5 zero write keeps b2h", d, 8'h08);
    hwr(2'd0, 8'h08); hrd(2'd0, d); check("R5 clear b2h", d, 8'h00);

    // R10 no pending while disabled
    post(30, 1);
    hrd(2'd2, d); check("R10 disabled post no pending", d, 8'h00);
    check("R10 irq low", irq, 0);
    // R8 enable with attention set
    hwr(2'd2, 8'h01); hrd(2'd2, d); check("R8 enable with b2h pends", d, 8'h03);
    check("R12 irq follows pending", irq, 1);
    // R9 ack
    hwr(2'd2, 8'h03); hrd(2'd2, d); check("R9 ack clears pending", d, 8'h01);
    check("R9 irq drops", irq, 0);
    hwr(2'd2, 8'h01); hrd(2'd2, d); check("R8 same enable no change", d, 8'h01);
    // R8 disable clears pending
    hwr(2'd2, 8'h00); hwr(2'd2, 8'h01); hwr(2'd2, 8'h00);
    hrd(2'd2, d); check("R8 disable clears pending", d, 8'h00);
    // R9 enable+ack in one write
    hwr(2'd2, 8'h03); hrd(2'd2, d); check("R9 enable then ack same write", d, 8'h01);

    // R10 post while enabled
    hwr(2'd0, 8'h08);
    post(31, 1);
    hrd(2'd2, d); check("R10 post raises pending", d, 8'h03);
    hwr(2'd2, 8'h03);

    // R11 SMS with b2h set
    sms(1'b1);
    hrd(2'd0, d); check("R11 sms flag set", d, 8'h18);
    hrd(2'd2, d); check("R11 sms blocked by b2h", d, 8'h01);
    sms(1'b0);
    hwr(2'd0, 8'h08);
    sms(1'b1);
    hrd(2'd2, d); check("R11 sms raises pending", d, 8'h03);
    check("R11 irq on sms", irq, 1);
    sms(1'b0);
    hrd(2'd2, d); check("R11 sms drop clears pending", d, 8'h01);
    sms(1'b1);
    hwr(2'd0, 8'h10); hrd(2'd0, d); check("R5 clear sms flag", d, 8'h00);
    hwr(2'd2, 8'h03);

    // R12 gating
    sms(1'b1);
    @(negedge clk); irq_allow = 1'b0;
    @(negedge clk);
    check("R12 irq gated off", irq, 0);
    hrd(2'd2, d); check("R12 pending held while gated", d, 8'h03);
    irq_allow = 1'b1;
    @(negedge clk); check("R12 irq returns", irq, 1);

    // R1 reset mid-operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irq after cold reset", irq, 0);
    hrd(2'd2, d); check("R1 mask after cold reset", d, 8'h00);
    hrd(2'd0, d); check("R1 ctl after cold reset", d, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule